// File: doc/BRIEF.md
# Trap State and Interrupt Pending Register Unit

This unit holds the state a 32-bit processor needs to take and return from traps. It keeps three 32-bit registers. The first is the saved trap address. The second is the trap reason word, which holds a 4-bit reason code and a set of sticky pending flags, one per hardware interrupt line. The third is the mode word, which holds an 8-bit interrupt mask and a three-level stack of (user-mode, interrupt-enable) bit pairs. The processor pulses `trap_take` with a reason code and its already-incremented PC. It pulses `trap_return` when a handler finishes. Software reads and writes the three registers through a single-address register port.

When a trap is taken, the unit rewinds the incremented PC by one instruction (4 bytes) and stores it. It latches the reason code. It pushes the mode stack, which drops the processor into kernel mode with interrupts off. A return pops the stack. Hardware interrupt requests are caught in the pending flags whatever the mask or enable state, and they stay there until software clears them. The unit raises an interrupt request when an enabled, unmasked flag is pending. The handler entry address is a fixed output.

All pins are plain control and status signals. The unit has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `sysctl_trap_regs`

## Requirements
- R1: Synchronous active-high `rst` clears the saved address, the reason word and the mode word to 0 on the next edge, so the processor is in kernel mode with interrupts off and every mask bit 0; `irq_req` is then 0.
- R2: `handler_addr` is always 0x8000_0080.
- R3: A cycle with `trap_take` high sets the saved address to `trap_pc_inc - 4` (mod 2^32) on that edge, and this wins over a software write to address 0 in the same cycle. Otherwise a software write to address 0 loads all 32 bits.
- R4: A cycle with `trap_take` high latches `trap_code` into reason-word bits 5:2. At any other time those bits hold their value, and software writes to them are ignored.
- R5: Reason-word bit 10+i (i = 0..4) is set on the edge after `hw_irq[i]` is high in a cycle, regardless of mask or enable. It stays set until a software write to address 1 carries a 1 in bit 10+i. If a request arrives in the same cycle as a clear, the request wins and the bit stays set.
- R6: A software write to address 1 with a 0 in a pending bit leaves that bit unchanged. Reason-word bits 1:0, 9:6 and 31:15 always read 0.
- R7: On a trap, mode-word bits 5:0 become {old bits 3:0, 2'b00}: the previous pair moves to the oldest slot, the current pair moves to the previous slot, and the current pair becomes kernel with interrupts off. The mask is unchanged.
- R8: On a return without a trap in the same cycle, mode bits 3:0 take old bits 5:2 and bits 5:4 keep their value. If a trap and a return arrive in the same cycle, the trap behaviour of R7 applies.
- R9: A software write to address 2 loads mode-word bits 15:8 (mask) and 5:0 (stack) from the write data, and bits 31:16 and 7:6 read 0. The write is ignored in a cycle with `trap_take` or `trap_return` high.
- R10: `irq_req` is 1 exactly when, for some i in 0..4, reason-word bit 10+i and mode-word bit 10+i are both 1 and mode-word bit 0 (current enable) is 1. It follows the registers in the same cycle.
- R11: `csr_rd_data` shows the register selected by `csr_addr`, combinationally: 0 selects the saved address, 1 the reason word, 2 the mode word and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_take | input | 1 | Take a trap this cycle |
| trap_code | input | 4 | Reason code recorded on a trap |
| trap_pc_inc | input | 32 | Incremented PC of the trapping instruction |
| hw_irq | input | 5 | Hardware interrupt request lines |
| trap_return | input | 1 | Return from trap this cycle |
| csr_wr_en | input | 1 | Software register write strobe |
| csr_addr | input | 2 | Register select for read and write |
| csr_wr_data | input | 32 | Software write data |
| csr_rd_data | output | 32 | Selected register value |
| epc_q | output | 32 | Saved trap address |
| cause_q | output | 32 | Reason word: code and pending flags |
| status_q | output | 32 | Mode word: mask and mode stack |
| irq_req | output | 1 | Interrupt request to the processor |
| handler_addr | output | 32 | Fixed handler entry address |

## Verification
The hardest case to reach from the ports is the full product of pending flags, mask bits and the current enable bit behind `irq_req`. The pending flags can only be built up through the request lines and taken down through clearing writes. To reach every case, the bench clears all flags for each of the 32 pending patterns, raises that pattern for one cycle, and then writes every mask pattern with the enable both off and on. The same-cycle collisions get their own directed cycles: a request arriving with its clear, a trap coinciding with a return, and a trap coinciding with a mode-word or address write. The mode stack is swept across all 64 starting values, each through an entry, a return and a combined entry and return.

// File: rtl/sysctl_trap_pkg.sv
package sysctl_trap_pkg;
  localparam int XLEN     = 32;
  localparam int N_HW     = 5;
  localparam int CODE_W   = 4;
  localparam int MASK_W   = 8;
  localparam int DEPTH    = 3;
  localparam int CODE_LO  = 2;
  localparam int PEND_LO  = 10;
  localparam int MASK_LO  = 8;
  localparam logic [XLEN-1:0] HANDLER = 32'h8000_0080;

  typedef enum logic [1:0] {
    SEL_EPC    = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/trap_pend_latch.sv
module trap_pend_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)         bit_q <= 1'b0;
      else if (req[g]) bit_q <= 1'b1;
      else if (clr[g]) bit_q <= 1'b0;
    end
    assign pend[g] = bit_q;

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      req[g] |=> pend[g]); // R5
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (pend[g] && !clr[g]) |=> pend[g]); // R5
    AST_PEND_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      (!pend[g] && !req[g]) |=> !pend[g]); // R5
  end
endmodule

// File: rtl/trap_mode_stack.sv
module trap_mode_stack #(
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic               pop,
  input  logic               wr_en,
  input  logic [2*DEPTH-1:0] wr_data,
  output logic [2*DEPTH-1:0] stack_q
);
  localparam int SW = 2 * DEPTH;

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [1:0] pair_q;
    logic [1:0] from_below;
    logic [1:0] from_above;

    if (g == 0) begin : g_bottom
      assign from_below = 2'b00;
    end else begin : g_mid
      assign from_below = stack_q[2*(g-1) +: 2];
    end

    if (g == DEPTH - 1) begin : g_top
      assign from_above = pair_q;
    end else begin : g_inner
      assign from_above = stack_q[2*(g+1) +: 2];
    end

    always_ff @(posedge clk) begin
      if (rst)        pair_q <= 2'b00;
      else if (push)  pair_q <= from_below;
      else if (pop)   pair_q <= from_above;
      else if (wr_en) pair_q <= wr_data[2*g +: 2];
    end
    assign stack_q[2*g +: 2] = pair_q;
  end

  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (rst)
    push |=> (stack_q[1:0] == 2'b00)); // R7
  AST_ENTRY_SHIFT: assert property (@(posedge clk) disable iff (rst)
    push |=> (stack_q[SW-1:2] == $past(stack_q[SW-3:0]))); // R7
  AST_RETURN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (stack_q[SW-3:0] == $past(stack_q[SW-1:2]))); // R8
endmodule

// File: rtl/trap_epc_code.sv
module trap_epc_code #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc_inc,
  input  logic              epc_wr,
  input  logic [XLEN-1:0]   epc_wdata,
  output logic [XLEN-1:0]   epc_q,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q  <= '0;
      code_q <= '0;
    end else if (take) begin
      epc_q  <= pc_inc - INSN_BYTES;
      code_q <= code;
    end else if (epc_wr) begin
      epc_q  <= epc_wdata;
    end
  end

  AST_EPC_REWIND: assert property (@(posedge clk) disable iff (rst)
    take |=> (epc_q == $past(pc_inc) - INSN_BYTES)); // R3
  AST_CODE_LATCH: assert property (@(posedge clk) disable iff (rst)
    take |=> (code_q == $past(code))); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(code_q)); // R4
endmodule

// File: rtl/sysctl_trap_regs.sv
module sysctl_trap_regs
  import sysctl_trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_take,
  input  logic [3:0]      trap_code,
  input  logic [31:0]     trap_pc_inc,
  input  logic [4:0]      hw_irq,
  input  logic            trap_return,
  input  logic            csr_wr_en,
  input  logic [1:0]      csr_addr,
  input  logic [31:0]     csr_wr_data,
  output logic [31:0]     csr_rd_data,
  output logic [31:0]     epc_q,
  output logic [31:0]     cause_q,
  output logic [31:0]     status_q,
  output logic            irq_req,
  output logic [31:0]     handler_addr
);
  localparam int SW       = 2 * DEPTH;
  localparam int MASK_OFF = PEND_LO - MASK_LO;

  csr_sel_e sel;
  assign sel = csr_sel_e'(csr_addr);

  logic              wr_epc, wr_cause, wr_status;
  logic [N_HW-1:0]   pend_clr, pend;
  logic [CODE_W-1:0] code_q;
  logic [SW-1:0]     stack_q;
  logic [MASK_W-1:0] mask_q;

  assign wr_epc    = csr_wr_en && (sel == SEL_EPC);
  assign wr_cause  = csr_wr_en && (sel == SEL_CAUSE);
  assign wr_status = csr_wr_en && (sel == SEL_STATUS) && !trap_take && !trap_return;
  assign pend_clr  = wr_cause ? csr_wr_data[PEND_LO +: N_HW] : '0;

  trap_epc_code #(.XLEN(XLEN), .CODE_W(CODE_W)) u_epc (
    .clk(clk), .rst(rst), .take(trap_take), .code(trap_code),
    .pc_inc(trap_pc_inc), .epc_wr(wr_epc), .epc_wdata(csr_wr_data),
    .epc_q(epc_q), .code_q(code_q)
  );

  trap_pend_latch #(.N(N_HW)) u_pend (
    .clk(clk), .rst(rst), .req(hw_irq), .clr(pend_clr), .pend(pend)
  );

  trap_mode_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(trap_take), .pop(trap_return),
    .wr_en(wr_status), .wr_data(csr_wr_data[SW-1:0]), .stack_q(stack_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '0;
    else if (wr_status) mask_q <= csr_wr_data[MASK_LO +: MASK_W];
  end

  always_comb begin
    cause_q = '0;
    cause_q[CODE_LO +: CODE_W] = code_q;
    cause_q[PEND_LO +: N_HW]   = pend;
    status_q = '0;
    status_q[MASK_LO +: MASK_W] = mask_q;
    status_q[SW-1:0]            = stack_q;
  end

  assign irq_req      = (|(pend & mask_q[MASK_OFF +: N_HW])) & stack_q[1'b0];
  assign handler_addr = HANDLER;

  always_comb begin
    unique case (sel)
      SEL_EPC:    csr_rd_data = epc_q;
      SEL_CAUSE:  csr_rd_data = cause_q;
      SEL_STATUS: csr_rd_data = status_q;
      default:    csr_rd_data = '0;
    endcase
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (epc_q == '0 && cause_q == '0 && status_q == '0)); // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !status_q[0] |-> !irq_req); // R10
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (cause_q[PEND_LO +: N_HW] != '0)); // R10
  AST_MASK_FROZEN_ON_TRAP: assert property (@(posedge clk) disable iff (rst)
    (trap_take || trap_return) |=> $stable(status_q[MASK_LO +: MASK_W])); // R9
endmodule

// File: tb/sysctl_trap_regs_tb.sv
module sysctl_trap_regs_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, trap_take, trap_return, csr_wr_en, irq_req;
  logic [3:0]  trap_code;
  logic [31:0] trap_pc_inc, csr_wr_data, csr_rd_data, epc_q, cause_q, status_q, handler_addr;
  logic [4:0]  hw_irq;
  logic [1:0]  csr_addr;

  sysctl_trap_regs u_dut (
    .clk(clk), .rst(rst), .trap_take(trap_take), .trap_code(trap_code),
    .trap_pc_inc(trap_pc_inc), .hw_irq(hw_irq), .trap_return(trap_return),
    .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wr_data(csr_wr_data),
    .csr_rd_data(csr_rd_data), .epc_q(epc_q), .cause_q(cause_q),
    .status_q(status_q), .irq_req(irq_req), .handler_addr(handler_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_epc;
  logic [3:0]  m_code;
  logic [4:0]  m_pend;
  logic [7:0]  m_mask;
  logic [5:0]  m_stk;

  function automatic logic [31:0] m_cause();
    return {17'b0, m_pend, 4'b0, m_code, 2'b00};
  endfunction
  function automatic logic [31:0] m_status();
    return {16'b0, m_mask, 2'b00, m_stk};
  endfunction
  function automatic logic m_irq();
    return (|(m_pend & m_mask[6:2])) & m_stk[0];
  endfunction
  function automatic logic [31:0] m_rd();
    case (csr_addr)
      2'd0:    return m_epc;
      2'd1:    return m_cause();
      2'd2:    return m_status();
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3 saved address", epc_q, m_epc);
    chk("R4 reason code", {28'b0, cause_q[5:2]}, {28'b0, m_code});
    chk("R5 pending flags", {27'b0, cause_q[14:10]}, {27'b0, m_pend});
    chk("R6 reason word", cause_q, m_cause());
    chk("R9 mode word", status_q, m_status());
    chk("R10 irq_req", {31'b0, irq_req}, {31'b0, m_irq()});
    chk("R11 read port", csr_rd_data, m_rd());
    chk("R2 handler", handler_addr, 32'h8000_0080);
  endtask

  task automatic idle();
    trap_take = 0; trap_return = 0; csr_wr_en = 0; hw_irq = '0;
    trap_code = '0; trap_pc_inc = '0; csr_wr_data = '0;
  endtask

  // Inputs are set just after a negedge; the model steps, then outputs are checked at the next negedge.
  task automatic tick();
    logic [31:0] n_epc; logic [3:0] n_code; logic [4:0] n_pend;
    logic [7:0] n_mask; logic [5:0] n_stk; logic wr_s;
    wr_s = csr_wr_en && csr_addr == 2'd2 && !trap_take && !trap_return;
    if (rst) begin
      n_epc = '0; n_code = '0; n_pend = '0; n_mask = '0; n_stk = '0;
    end else begin
      n_epc  = trap_take ? trap_pc_inc - 32'd4 : (csr_wr_en && csr_addr == 2'd0) ? csr_wr_data : m_epc;
      n_code = trap_take ? trap_code : m_code;
      n_pend = (m_pend & ~((csr_wr_en && csr_addr == 2'd1) ? csr_wr_data[14:10] : 5'd0)) | hw_irq;
      n_mask = wr_s ? csr_wr_data[15:8] : m_mask;
      n_stk  = trap_take ? {m_stk[3:0], 2'b00} : trap_return ? {m_stk[5:4], m_stk[5:2]} :
               wr_s ? csr_wr_data[5:0] : m_stk;
    end
    @(negedge clk);
    m_epc = n_epc; m_code = n_code; m_pend = n_pend; m_mask = n_mask; m_stk = n_stk;
    check_all();
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    csr_wr_en = 1; csr_addr = a; csr_wr_data = d;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); csr_addr = 0; rst = 1;
    m_epc = 'x; m_code = 'x; m_pend = 'x; m_mask = 'x; m_stk = 'x;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    // R1 reset state
    chk("R1 reset saved address", epc_q, 32'h0);
    chk("R1 reset reason word", cause_q, 32'h0);
    chk("R1 reset mode word", status_q, 32'h0);
    chk("R1 reset irq_req", {31'b0, irq_req}, 32'h0);

    // R3 R4 R7: every code, two PC patterns including the wrap below zero
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 2; p++) begin
        trap_take = 1; trap_code = 4'(c);
        trap_pc_inc = p ? 32'(c * 4) : 32'h8000_1000 + 32'(c * 32'h104);
        csr_addr = 2'(c);
        tick();
        chk("R3 rewound address", epc_q, (p ? 32'(c * 4) : 32'h8000_1000 + 32'(c * 32'h104)) - 32'd4);
        chk("R7 entry kernel off", {30'b0, status_q[1:0]}, 32'h0);
        trap_return = 1; tick();
      end
    end

    // R3 software write and trap priority
    wr(2'd0, 32'hCAFE_F00D);
    chk("R3 software write", epc_q, 32'hCAFE_F00D);
    trap_take = 1; trap_code = 4'd12; trap_pc_inc = 32'h0000_2004;
    csr_wr_en = 1; csr_addr = 2'd0; csr_wr_data = 32'h1111_1111;
    tick();
    chk("R3 trap beats write", epc_q, 32'h0000_2000);
    trap_return = 1; tick();

    // R4 R6 reason code ignores writes, unused bits read zero
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R4 code kept on write", {28'b0, cause_q[5:2]}, 32'd12);
    chk("R6 unused bits zero", cause_q & 32'hFFFF_83C3, 32'h0);

    // R5 R6 pending capture, hold, partial clear
    csr_addr = 2'd1;
    for (int p = 0; p < 32; p++) begin
      hw_irq = 5'(p); tick();
      tick();
      chk("R5 sticky after request", {27'b0, cause_q[14:10]}, 32'(p));
      wr(2'd1, {17'b0, 5'b10101, 10'b0});
      chk("R6 zero leaves bit", {27'b0, cause_q[14:10]}, 32'(p & 5'b01010));
      wr(2'd1, 32'h0000_7C00);
    end
    for (int b = 0; b < 5; b++) begin
      hw_irq = 5'(1 << b); tick();
      hw_irq = 5'(1 << b); csr_wr_en = 1; csr_addr = 2'd1; csr_wr_data = 32'(1 << (10 + b));
      tick();
      chk("R5 request beats clear", {27'b0, cause_q[14:10]}, 32'(1 << b));
      wr(2'd1, 32'h0000_7C00);
      chk("R5 clear", {27'b0, cause_q[14:10]}, 32'h0);
    end

    // R10 every pending x mask x enable
    for (int p = 0; p < 32; p++) begin
      wr(2'd1, 32'h0000_7C00);
      hw_irq = 5'(p); tick();
      for (int m = 0; m < 32; m++) begin
        for (int e = 0; e < 2; e++) begin
          wr(2'd2, {16'b0, 1'b1, 5'(m), 2'b11, 7'b0, 1'(e)});
          chk("R10 irq product", {31'b0, irq_req}, {31'b0, 1'((|(p & m)) && e)});
        end
      end
    end

    // R7 R8 R9 mode stack over every start value
    for (int v = 0; v < 64; v++) begin
      logic [5:0] s;
      s = 6'(v);
      wr(2'd2, {16'b0, 8'hA5, 2'b00, s});
      trap_take = 1; tick();
      chk("R7 entry push", {26'b0, status_q[5:0]}, {26'b0, s[3:0], 2'b00});
      chk("R7 mask kept", {24'b0, status_q[15:8]}, 32'hA5);
      trap_return = 1; tick();
      chk("R8 return pop", {26'b0, status_q[5:0]}, {26'b0, s[3:2], s[3:0]});
      wr(2'd2, {16'b0, 8'h3C, 2'b00, s});
      trap_return = 1; tick();
      chk("R8 pop keeps oldest", {26'b0, status_q[5:0]}, {26'b0, s[5:4], s[5:2]});
      wr(2'd2, {16'b0, 8'h3C, 2'b00, s});
      trap_take = 1; trap_return = 1; tick();
      chk("R8 trap wins over return", {26'b0, status_q[5:0]}, {26'b0, s[3:0], 2'b00});
      wr(2'd2, {16'b0, 8'h3C, 2'b00, s});
      trap_take = 1; csr_wr_en = 1; csr_addr = 2'd2; csr_wr_data = ~{16'b0, 8'h3C, 2'b00, s};
      tick();
      chk("R9 write ignored on trap", {16'b0, status_q[15:0]}, {16'b0, 8'h3C, 2'b00, s[3:0], 2'b00});
      trap_return = 1; csr_wr_en = 1; csr_addr = 2'd2; csr_wr_data = 32'hFFFF_FFFF;
      tick();
      chk("R9 write ignored on return", {24'b0, status_q[15:8]}, 32'h3C);
    end
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R9 writable bits only", status_q, 32'h0000_FF3F);

    // R11 read port over all selects
    for (int a = 0; a < 4; a++) begin
      csr_addr = 2'(a); tick();
      chk("R11 select", csr_rd_data, (a == 0) ? epc_q : (a == 1) ? cause_q : (a == 2) ? status_q : 32'h0);
    end

    // R1 reset from a busy state
    hw_irq = 5'h1F; tick();
    rst = 1; tick(); rst = 0;
    chk("R1 reset mid-run", epc_q | cause_q | status_q, 32'h0);
    chk("R1 irq cleared", {31'b0, irq_req}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule